// File: doc/BRIEF.md
# Receive Two-Frame Slip Buffer

This block sits on the receive side of a 1.544 Mb/s line interface. It stores the 24 channel bytes of each incoming DS1 frame, which arrive at the pace of the clock recovered from the line. It plays them out onto a 32-timeslot, 2.048 Mb/s system bus at the pace of the system backplane clock. The storage holds exactly two DS1 frames. While the reader works through one frame, the writer can fill the other, so the block absorbs wander and low-frequency jitter as well as converting the rate.

Both timing domains appear here as enables in a single clock. Each write strobe delivers one DS1 channel byte. Each read strobe consumes one system timeslot. Timeslots whose index is a multiple of four carry the idle code, and the other 24 timeslots carry the channels in ascending order. At each read frame boundary the block measures how far the writer is ahead of the start of the frame it is about to read. While that distance stays within roughly 140 unit intervals of the balanced point, reading alternates between the two frames. Beyond that window the block keeps the current frame index for one more frame, so one whole frame is either repeated or dropped. It then emits a one-cycle slip pulse and a sticky direction flag.

Top module: `rx_slip_buffer`

## Requirements
- R1: After reset, rd_data is 0xFF, slip_pulse and slip_dir are 0, fill_delay is 0, every storage byte reads as 0xFF, the write position is 0 and the first read frame is frame 1.
- R2: Each wr_en cycle stores wr_data at the next of 48 positions (frame f, channel c at position 24*f+c), wrapping from 47 to 0; with wr_en low nothing is stored.
- R3: A read strobe on timeslot s (counting 0..31 per read frame) sets rd_data on the next clock edge: 0xFF when s mod 4 is 0, otherwise channel s - s/4 - 1 of the current read frame.
- R4: On the strobe of timeslot 31 the block computes d = (write position - 24*next frame) mod 48, where next frame is the other frame, and presents d on fill_delay one cycle later.
- R5: When 6 <= d <= 42, no slip occurs, and the next read frame is the other frame.
- R6: When d < 6, slip_pulse fires, slip_dir becomes 0 (repeat), and the same frame index is read again, so its old contents are replayed.
- R7: When d > 42, slip_pulse fires, slip_dir becomes 1 (skip), and the same frame index is read again, now holding newer data, so one received frame is dropped.
- R8: slip_pulse is high for exactly one cycle, directly after a timeslot-31 strobe.
- R9: slip_dir holds its value until the next slip.
- R10: With rd_en low, rd_data, fill_delay and the read position do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both domains |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one DS1 channel byte |
| wr_data | input | 8 | Received channel byte |
| rd_en | input | 1 | Read strobe, one system timeslot |
| rd_data | output | 8 | System bus byte for the strobed timeslot |
| slip_pulse | output | 1 | One-cycle slip event |
| slip_dir | output | 1 | Last slip direction: 0 repeat, 1 skip |
| fill_delay | output | 6 | Distance in bytes measured at the last read frame boundary |

## Verification
The assertions assume that the read side advances only through rd_en. They also assume that at least 31 strobes separate two frame boundaries, which keeps the slip pulse isolated. The stimulus keeps every strobe a single cycle long and inserts an idle cycle after each one. It holds both enables low during reset. It fills the buffer with writes between read frames, so each boundary sees a known write position that the vector table chooses.

// File: rtl/rx_slip_pkg.sv
package rx_slip_pkg;

  localparam logic [7:0] IDLE_CODE = 8'hFF;

  // every fourth system timeslot carries no channel
  function automatic bit slot_is_idle(input int s);
    return (s % 4) == 0;
  endfunction

  // channel carried by a non-idle timeslot
  function automatic int slot_chan(input int s);
    return ((s % 4) == 0) ? 0 : (s - s / 4 - 1);
  endfunction

  // bytes the writer is ahead of the start of frame f
  function automatic int frame_delay(input int wp, input int f,
                                     input int ch, input int depth);
    return (wp + depth - f * ch) % depth;
  endfunction

endpackage

// File: rtl/rxsb_wr_ptr.sv
module rxsb_wr_ptr #(
  parameter int DEPTH = 48,
  parameter int PW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  output logic [PW-1:0] wr_pos
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)     wr_pos <= '0;
    else if (wr_en) wr_pos <= (wr_pos == LAST) ? '0 : wr_pos + 1'b1;
  end

  a_r2_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(wr_pos));
  a_r2_wr_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pos <= LAST);
endmodule

// File: rtl/rxsb_store.sv
module rxsb_store #(
  parameter int DEPTH = 48,
  parameter int PW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_pos,
  input  logic [7:0]    wr_data,
  input  logic [PW-1:0] rd_addr,
  output logic [7:0]    rd_byte
);
  import rx_slip_pkg::*;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= IDLE_CODE;
    end else if (wr_en) begin
      mem[wr_pos] <= wr_data;
    end
  end

  assign rd_byte = mem[rd_addr];
endmodule

// File: rtl/rxsb_rd_ctrl.sv
module rxsb_rd_ctrl #(
  parameter int CHANNELS = 24,
  parameter int SLOTS    = 32,
  parameter int DEPTH    = 48,
  parameter int PW       = 6,
  parameter int SW       = 5,
  parameter int LOW_LIM  = 6,
  parameter int HIGH_LIM = 42
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [PW-1:0] wr_pos,
  output logic [PW-1:0] rd_addr,
  output logic          slot_idle,
  output logic          slip_pulse,
  output logic          slip_dir,
  output logic [PW-1:0] fill_delay
);
  import rx_slip_pkg::*;

  localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);
  localparam logic [PW-1:0] LOW_V     = PW'(LOW_LIM);
  localparam logic [PW-1:0] HIGH_V    = PW'(HIGH_LIM);

  logic [SW-1:0] slot;
  logic          frame;
  logic          next_frame;
  logic          boundary;
  logic [PW-1:0] d_now;
  logic          too_close;
  logic          too_far;
  logic          slip_now;
  logic [PW-1:0] chan;

  assign boundary   = rd_en && (slot == LAST_SLOT);
  assign next_frame = ~frame;
  assign d_now      = PW'(frame_delay(int'(wr_pos), int'(next_frame), CHANNELS, DEPTH));
  assign too_close  = d_now < LOW_V;
  assign too_far    = d_now > HIGH_V;
  assign slip_now   = boundary && (too_close || too_far);

  assign slot_idle  = slot_is_idle(int'(slot));
  assign chan       = slot_idle ? '0 : PW'(slot_chan(int'(slot)));
  assign rd_addr    = frame ? chan + PW'(CHANNELS) : chan;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot       <= '0;
      frame      <= 1'b1;
      slip_pulse <= 1'b0;
      slip_dir   <= 1'b0;
      fill_delay <= '0;
    end else begin
      slip_pulse <= slip_now;
      if (rd_en) slot <= boundary ? '0 : slot + 1'b1;
      if (boundary) begin
        fill_delay <= d_now;
        frame      <= slip_now ? frame : next_frame;
      end
      if (slip_now) slip_dir <= too_far;
    end
  end

  // R8: slip only right after a last-timeslot strobe, never two cycles running
  a_r8_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    slip_pulse |-> $past(rd_en) && ($past(slot) == LAST_SLOT));
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    slip_pulse |=> !slip_pulse);
  // R5: a boundary without slip reported an in-window distance
  a_r5_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    $past(boundary) && !slip_pulse |-> (fill_delay >= LOW_V) && (fill_delay <= HIGH_V));
  // R6 / R7: direction matches the side of the window that was crossed
  a_r6_repeat_dir: assert property (@(posedge clk) disable iff (!rst_n)
    slip_pulse && (fill_delay < LOW_V) |-> !slip_dir);
  a_r7_skip_dir: assert property (@(posedge clk) disable iff (!rst_n)
    slip_pulse && (fill_delay > HIGH_V) |-> slip_dir);
  // R9: direction only moves with a slip
  a_r9_dir_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !slip_pulse |-> $stable(slip_dir));
  // R10: read position frozen without strobe
  a_r10_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(slot) && $stable(fill_delay));
endmodule

// File: rtl/rx_slip_buffer.sv
module rx_slip_buffer #(
  parameter int CHANNELS    = 24,
  parameter int SLOTS       = 32,
  parameter int WANDER_UI   = 140,
  parameter int UI_PER_BYTE = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       slip_pulse,
  output logic       slip_dir,
  output logic [5:0] fill_delay
);
  import rx_slip_pkg::*;

  localparam int DEPTH    = 2 * CHANNELS;
  localparam int PW       = $clog2(DEPTH);
  localparam int SW       = $clog2(SLOTS);
  localparam int TOL      = (WANDER_UI + UI_PER_BYTE - 1) / UI_PER_BYTE;
  localparam int LOW_LIM  = CHANNELS - TOL;
  localparam int HIGH_LIM = CHANNELS + TOL;

  logic [PW-1:0] wr_pos;
  logic [PW-1:0] rd_addr;
  logic [7:0]    rd_byte;
  logic          slot_idle;
  logic [PW-1:0] fill_int;

  rxsb_wr_ptr #(.DEPTH(DEPTH), .PW(PW)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_pos(wr_pos)
  );

  rxsb_store #(.DEPTH(DEPTH), .PW(PW)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_pos(wr_pos),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_byte(rd_byte)
  );

  rxsb_rd_ctrl #(
    .CHANNELS(CHANNELS), .SLOTS(SLOTS), .DEPTH(DEPTH), .PW(PW), .SW(SW),
    .LOW_LIM(LOW_LIM), .HIGH_LIM(HIGH_LIM)
  ) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_pos(wr_pos),
    .rd_addr(rd_addr), .slot_idle(slot_idle), .slip_pulse(slip_pulse),
    .slip_dir(slip_dir), .fill_delay(fill_int)
  );

  assign fill_delay = 6'(fill_int);

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= IDLE_CODE;
    else if (rd_en) rd_data <= slot_idle ? IDLE_CODE : rd_byte;
  end

  // R10: output byte frozen without a read strobe
  a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  // R3: idle timeslots always show the idle code
  a_r3_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && slot_idle |=> rd_data == IDLE_CODE);
endmodule

// File: tb/rx_slip_buffer_test.sv
module rx_slip_buffer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       slip_pulse;
  logic       slip_dir;
  logic [5:0] fill_delay;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] model [48];
  int wcount;
  int exp_frame;
  logic       b_pulse, b_dir;
  logic [5:0] b_fill;

  localparam int NV = 8;
  localparam int VEC_N    [NV] = '{0, 5, 6, 24, 42, 43, 47, 50};
  localparam int VEC_D    [NV] = '{0, 5, 6, 24, 42, 43, 47, 2};
  localparam int VEC_SLIP [NV] = '{1, 1, 0, 0, 0, 1, 1, 1};
  localparam int VEC_DIR  [NV] = '{0, 0, 0, 0, 0, 1, 1, 0};

  rx_slip_buffer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .slip_pulse(slip_pulse),
    .slip_dir(slip_dir), .fill_delay(fill_delay)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 48; i++) model[i] = 8'hFF;
    wcount = 0;
    exp_frame = 1;
  endtask

  task automatic write_n(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = 8'((wcount * 5 + 17) & 255);
      model[wcount % 48] = wr_data;
      wcount++;
      @(negedge clk);
      wr_en = 1'b0;
    end
  endtask

  // reads 32 timeslots; returns mismatch count and boundary flags
  task automatic read_frame(output int bad);
    logic [7:0] e;
    bad = 0;
    for (int s = 0; s < 32; s++) begin
      @(negedge clk);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      e = ((s % 4) == 0) ? 8'hFF : model[exp_frame * 24 + s - s / 4 - 1];
      if (rd_data !== e) begin
        bad++;
        $display("  slot %0d got %02h want %02h", s, rd_data, e);
      end
    end
    b_pulse = slip_pulse;
    b_dir   = slip_dir;
    b_fill  = fill_delay;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int bad;
    logic [7:0] hold_d;
    do_reset();
    @(negedge clk);
    check(rd_data == 8'hFF, "R1 rd_data", rd_data, 255);
    check(slip_pulse == 1'b0, "R1 slip_pulse", slip_pulse, 0);
    check(slip_dir == 1'b0, "R1 slip_dir", slip_dir, 0);
    check(fill_delay == 6'd0, "R1 fill_delay", fill_delay, 0);

    for (int v = 0; v < NV; v++) begin
      do_reset();
      write_n(VEC_N[v]);
      read_frame(bad);
      check(bad == 0, "R1 R3 first frame data", bad, 0);
      check(b_fill == 6'(VEC_D[v]), "R4 fill_delay", b_fill, VEC_D[v]);
      if (VEC_SLIP[v] == 0)
        check(b_pulse == 1'b0, "R5 no slip", b_pulse, 0);
      else if (VEC_DIR[v] == 0)
        check(b_pulse && !b_dir, "R6 repeat slip", {b_pulse, b_dir}, 2);
      else
        check(b_pulse && b_dir, "R7 skip slip", {b_pulse, b_dir}, 3);
      @(negedge clk);
      check(slip_pulse == 1'b0, "R8 pulse width", slip_pulse, 0);
      if (VEC_SLIP[v] == 0) exp_frame = 1 - exp_frame;
      read_frame(bad);
      check(bad == 0, "R2 R3 R5 R6 R7 next frame data", bad, 0);
    end

    // R9: skip, then an in-window boundary keeps the direction
    do_reset();
    write_n(45);
    read_frame(bad);
    check(b_pulse && b_dir, "R7 skip before R9", {b_pulse, b_dir}, 3);
    write_n(12);
    read_frame(bad);
    check(b_fill == 6'd9, "R4 wrapped distance", b_fill, 9);
    check(!b_pulse && b_dir, "R9 dir held", {b_pulse, b_dir}, 1);

    // R10: no strobes, toggling wr_data with wr_en low
    do_reset();
    write_n(30);
    read_frame(bad);
    exp_frame = 0;
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    hold_d = rd_data;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      wr_data = 8'(k * 40);
    end
    check(rd_data == hold_d, "R10 rd_data held", rd_data, hold_d);
    check(fill_delay == 6'd30, "R10 fill held", fill_delay, 30);
    for (int s = 1; s < 32; s++) begin
      @(negedge clk); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
      if (s == 1)
        check(rd_data == model[0], "R2 R10 slot1 after idle", rd_data, model[0]);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule